// File: doc/BRIEF.md
# Speculative Store Buffer with Atomicity Monitor

This block keeps every store that a core makes inside a speculatively executed critical section away from the rest of the system until the section is known to have run atomically. Stores land in a small private buffer, where writes to the same word are combined byte by byte. Loads from the core inside the section see the buffered bytes first. The block records which cache lines the section has read and which it has written. It watches the snooped coherence traffic and abandons the section when another agent touches that footprint in a way that would break atomicity. It also abandons the section when it runs out of room to track it.

For every newly buffered word the block asks the cache for exclusive ownership of its line in the same cycle. A commit is therefore accepted only once every buffered line is owned. The buffer then drains to the cache one entry per cycle while snoops are held off, so other agents see the whole section appear in one step. An abort throws away all buffered and tracked state at once and reports why it happened.

Top module: `swb_top`

## Requirements
- R1: After reset the block is outside any region: `spec_active`, `abort_pulse`, `commit_done`, `drain_valid`, `snp_stall` and `own_req_valid` are all 0.
- R2: `ctl_begin` outside a region opens one from the next cycle. Stores and loads presented while no region is open are ignored: no ownership request, no buffering, no forwarding.
- R3: Inside a region, a store to a word not yet buffered (word address `st_addr`) takes a free entry. In that same cycle it raises `own_req_valid` with `own_req_line` = `st_addr >> LINE_SHIFT`.
- R4: A store to a word already buffered merges into its entry. Each byte lane i with `st_be[i]`=1 replaces bits [8i+7:8i], the other lanes keep their old value, and the byte enables are ORed. No ownership request is raised.
- R5: A load inside a region whose word is buffered raises `ld_hit` in the same cycle. `ld_fwd_be` carries the entry's byte enables and `ld_fwd_data` carries the entry's data, with unenabled lanes zero. A load to an unbuffered word gives `ld_hit`=0.
- R6: No buffered store appears on the drain port (`drain_valid`=0) while the region is open.
- R7: A store to a new word while all ENTRIES entries are used, or a load to a new line while all RSET_DEPTH read-set slots are used, aborts with cause 2 (overflow).
- R8: A snoop of any type to a written line, or an invalidating snoop (`snp_inv`=1) to a read line, aborts with cause 1 (conflict). A non-invalidating snoop to a line that was only read does not abort.
- R9: An abort leaves the region at the clock edge where its condition is seen, drops all entries and access bits, and raises `abort_pulse` for exactly one cycle with `abort_cause`. `ctl_abort` aborts with cause 3.
- R10: `commit_ready` is 1 only when every buffered entry's line has received `own_gnt_valid`/`own_gnt_line`. `ctl_commit` is ignored when `commit_ready` is 0 or when a store arrives in the same cycle.
- R11: An accepted commit drains the entries one per cycle in allocation order on `drain_*`, with `snp_stall` high throughout. `commit_done` pulses for one cycle after the last entry. Committing an empty buffer pulses `commit_done` on the next cycle.
- R12: When several abort causes arise in one cycle, conflict beats overflow, and overflow beats a core abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_begin | input | 1 | Open a speculative region |
| ctl_commit | input | 1 | Request validation and drain |
| ctl_abort | input | 1 | Core-requested abort |
| st_valid | input | 1 | Core store strobe |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| ld_valid | input | 1 | Core load strobe |
| ld_addr | input | ADDR_W | Load word address |
| ld_hit | output | 1 | Load word found in buffer |
| ld_fwd_data | output | DATA_W | Forwarded bytes (unenabled lanes zero) |
| ld_fwd_be | output | DATA_W/8 | Lanes supplied by the buffer |
| snp_valid | input | 1 | Snoop strobe |
| snp_line | input | ADDR_W-LINE_SHIFT | Snooped line address |
| snp_inv | input | 1 | 1 = invalidating snoop, 0 = read snoop |
| snp_stall | output | 1 | Snoops held off during drain |
| own_req_valid | output | 1 | Exclusive-ownership request |
| own_req_line | output | ADDR_W-LINE_SHIFT | Line requested |
| own_gnt_valid | input | 1 | Exclusive-ownership grant |
| own_gnt_line | input | ADDR_W-LINE_SHIFT | Line granted |
| commit_ready | output | 1 | All buffered lines owned |
| drain_valid | output | 1 | Drain write strobe |
| drain_addr | output | ADDR_W | Drain word address |
| drain_data | output | DATA_W | Drain data |
| drain_be | output | DATA_W/8 | Drain byte enables |
| commit_done | output | 1 | One-cycle pulse after drain |
| abort_pulse | output | 1 | One-cycle abort pulse |
| abort_cause | output | 2 | 1 conflict, 2 overflow, 3 core |
| spec_active | output | 1 | Region open |

## Verification
The bench builds the block with four store entries, four read-set slots and four words per line. Both overflow limits can then be reached in a handful of stores or loads, and a few lines cover both the same-line merging and the cross-line snoop cases. Random rounds confine their stores to four words spread over two lines. This makes merges and fresh allocations frequent while never overflowing, so the drained contents of every round can be compared with a bench model.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
package swb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPEC  = 2'd1,
    ST_DRAIN = 2'd2
  } swb_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_OVERFLOW = 2'd2,
    CAUSE_CORE     = 2'd3
  } swb_cause_e;
endpackage

// File: rtl/swb_store_buf.sv
`timescale 1ns/1ps
module swb_store_buf #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ENTRIES    = 4,
  parameter int LINE_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      st_en,
  input  logic [ADDR_W-1:0]         st_addr,
  input  logic [DATA_W-1:0]         st_data,
  input  logic [DATA_W/8-1:0]       st_be,
  input  logic                      gnt_valid,
  input  logic [ADDR_W-LINE_SHIFT-1:0] gnt_line,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [ADDR_W-LINE_SHIFT-1:0] snp_line,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic                      st_hit,
  output logic                      full,
  output logic [$clog2(ENTRIES+1)-1:0] occ,
  output logic                      ld_match,
  output logic [DATA_W-1:0]         ld_data,
  output logic [DATA_W/8-1:0]       ld_be,
  output logic                      snp_hit,
  output logic                      all_granted,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [DATA_W/8-1:0]       rd_be
);
  localparam int BE_W   = DATA_W / 8;
  localparam int LINE_W = ADDR_W - LINE_SHIFT;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(ENTRIES + 1);

  logic [ADDR_W-1:0] e_addr [ENTRIES];
  logic [DATA_W-1:0] e_data [ENTRIES];
  logic [BE_W-1:0]   e_be   [ENTRIES];
  logic [ENTRIES-1:0] e_vld, e_gnt;
  logic [CNT_W-1:0]   count;
  logic [IDX_W-1:0]   st_idx;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_SHIFT];
  endfunction

  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_d,
                                                    input logic [DATA_W-1:0] new_d,
                                                    input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BE_W; b++)
      r[b*8 +: 8] = be[b] ? new_d[b*8 +: 8] : old_d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < BE_W; b++)
      m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  always_comb begin
    st_hit   = 1'b0;
    st_idx   = '0;
    ld_match = 1'b0;
    ld_data  = '0;
    ld_be    = '0;
    snp_hit  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (e_vld[i] && e_addr[i] == st_addr) begin
        st_hit = 1'b1;
        st_idx = IDX_W'(i);
      end
      if (e_vld[i] && e_addr[i] == ld_addr) begin
        ld_match = 1'b1;
        ld_be    = e_be[i];
        ld_data  = e_data[i] & lane_mask(e_be[i]);
      end
      if (e_vld[i] && line_of(e_addr[i]) == snp_line)
        snp_hit = 1'b1;
    end
  end

  assign full        = (count == CNT_W'(ENTRIES));
  assign occ         = count;
  assign all_granted = &(~e_vld | e_gnt);
  assign rd_addr     = e_addr[rd_idx];
  assign rd_data     = e_data[rd_idx];
  assign rd_be       = e_be[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0;
      e_gnt <= '0;
      count <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_addr[i] <= '0;
        e_data[i] <= '0;
        e_be[i]   <= '0;
      end
    end else if (clear) begin
      e_vld <= '0;
      e_gnt <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (gnt_valid && e_vld[i] && line_of(e_addr[i]) == gnt_line)
          e_gnt[i] <= 1'b1;
      if (st_en) begin
        if (st_hit) begin
          e_data[st_idx] <= merge_lanes(e_data[st_idx], st_data, st_be);
          e_be[st_idx]   <= e_be[st_idx] | st_be;
        end else if (!full) begin
          e_vld[count[IDX_W-1:0]]  <= 1'b1;
          e_gnt[count[IDX_W-1:0]]  <= gnt_valid && (line_of(st_addr) == gnt_line);
          e_addr[count[IDX_W-1:0]] <= st_addr;
          e_data[count[IDX_W-1:0]] <= merge_lanes('0, st_data, st_be);
          e_be[count[IDX_W-1:0]]   <= st_be;
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swb_read_set.sv
`timescale 1ns/1ps
module swb_read_set #(
  parameter int LINE_W     = 14,
  parameter int RSET_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rec_en,
  input  logic [LINE_W-1:0] rec_line,
  input  logic [LINE_W-1:0] snp_line,
  output logic              rec_ovf,
  output logic              snp_hit,
  output logic [$clog2(RSET_DEPTH+1)-1:0] occ
);
  localparam int IDX_W = $clog2(RSET_DEPTH);
  localparam int CNT_W = $clog2(RSET_DEPTH + 1);

  logic [LINE_W-1:0]     r_line [RSET_DEPTH];
  logic [RSET_DEPTH-1:0] r_vld;
  logic [CNT_W-1:0]      count;
  logic                  rec_hit, full;

  always_comb begin
    rec_hit = 1'b0;
    snp_hit = 1'b0;
    for (int i = 0; i < RSET_DEPTH; i++) begin
      if (r_vld[i] && r_line[i] == rec_line) rec_hit = 1'b1;
      if (r_vld[i] && r_line[i] == snp_line) snp_hit = 1'b1;
    end
  end

  assign full    = (count == CNT_W'(RSET_DEPTH));
  assign rec_ovf = rec_en && !rec_hit && full;
  assign occ     = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_vld <= '0;
      count <= '0;
      for (int i = 0; i < RSET_DEPTH; i++) r_line[i] <= '0;
    end else if (clear) begin
      r_vld <= '0;
      count <= '0;
    end else if (rec_en && !rec_hit && !full) begin
      r_vld[count[IDX_W-1:0]]  <= 1'b1;
      r_line[count[IDX_W-1:0]] <= rec_line;
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/swb_ctrl.sv
`timescale 1ns/1ps
module swb_ctrl
  import swb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic begin_req,
  input  logic commit_req,
  input  logic core_abort,
  input  logic conflict,
  input  logic overflow,
  input  logic store_now,
  input  logic all_granted,
  input  logic [$clog2(ENTRIES+1)-1:0] occ,
  output swb_state_e state,
  output logic clear,
  output logic commit_take,
  output logic [$clog2(ENTRIES)-1:0] drain_ptr,
  output logic abort_pulse,
  output logic [1:0] abort_cause,
  output logic commit_done
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  swb_state_e nxt;
  swb_cause_e cause;
  logic       drain_last, empty;

  assign empty      = (occ == '0);
  assign drain_last = (CNT_W'(drain_ptr) + 1'b1 == occ);

  always_comb begin
    cause = CAUSE_NONE;
    if (state == ST_SPEC) begin
      if (conflict)        cause = CAUSE_CONFLICT;
      else if (overflow)   cause = CAUSE_OVERFLOW;
      else if (core_abort) cause = CAUSE_CORE;
    end
  end

  assign commit_take = (state == ST_SPEC) && (cause == CAUSE_NONE) && commit_req
                       && all_granted && !store_now;

  always_comb begin
    nxt   = state;
    clear = 1'b0;
    unique case (state)
      ST_IDLE: if (begin_req) begin
        nxt   = ST_SPEC;
        clear = 1'b1;
      end
      ST_SPEC: begin
        if (cause != CAUSE_NONE) begin
          nxt   = ST_IDLE;
          clear = 1'b1;
        end else if (commit_take) begin
          nxt   = empty ? ST_IDLE : ST_DRAIN;
          clear = empty;
        end
      end
      ST_DRAIN: if (drain_last) begin
        nxt   = ST_IDLE;
        clear = 1'b1;
      end
      default: begin
        nxt   = ST_IDLE;
        clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      drain_ptr   <= '0;
      abort_pulse <= 1'b0;
      abort_cause <= 2'd0;
      commit_done <= 1'b0;
    end else begin
      state       <= nxt;
      drain_ptr   <= (state == ST_DRAIN) ? drain_ptr + 1'b1 : IDX_W'(0);
      abort_pulse <= (cause != CAUSE_NONE);
      abort_cause <= cause;
      commit_done <= (commit_take && empty) || (state == ST_DRAIN && drain_last);
    end
  end
endmodule

// File: rtl/swb_top.sv
`timescale 1ns/1ps
module swb_top
  import swb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ENTRIES    = 4,
  parameter int RSET_DEPTH = 4,
  parameter int LINE_SHIFT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_begin,
  input  logic                         ctl_commit,
  input  logic                         ctl_abort,
  input  logic                         st_valid,
  input  logic [ADDR_W-1:0]            st_addr,
  input  logic [DATA_W-1:0]            st_data,
  input  logic [DATA_W/8-1:0]          st_be,
  input  logic                         ld_valid,
  input  logic [ADDR_W-1:0]            ld_addr,
  output logic                         ld_hit,
  output logic [DATA_W-1:0]            ld_fwd_data,
  output logic [DATA_W/8-1:0]          ld_fwd_be,
  input  logic                         snp_valid,
  input  logic [ADDR_W-LINE_SHIFT-1:0] snp_line,
  input  logic                         snp_inv,
  output logic                         snp_stall,
  output logic                         own_req_valid,
  output logic [ADDR_W-LINE_SHIFT-1:0] own_req_line,
  input  logic                         own_gnt_valid,
  input  logic [ADDR_W-LINE_SHIFT-1:0] own_gnt_line,
  output logic                         commit_ready,
  output logic                         drain_valid,
  output logic [ADDR_W-1:0]            drain_addr,
  output logic [DATA_W-1:0]            drain_data,
  output logic [DATA_W/8-1:0]          drain_be,
  output logic                         commit_done,
  output logic                         abort_pulse,
  output logic [1:0]                   abort_cause,
  output logic                         spec_active
);
  localparam int LINE_W = ADDR_W - LINE_SHIFT;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(ENTRIES + 1);
  localparam int RCNT_W = $clog2(RSET_DEPTH + 1);

  swb_state_e          state;
  logic                in_spec, clear, commit_take;
  logic                wb_st_hit, wb_full, wb_ld_match, wb_snp_hit, wb_all_gnt;
  logic [CNT_W-1:0]    wb_occ;
  logic [RCNT_W-1:0]   rs_occ;
  logic                rs_ovf, rs_snp_hit;
  logic [IDX_W-1:0]    drain_ptr;
  logic                conflict_evt, overflow_evt, abort_evt, store_en;
  logic [DATA_W-1:0]   wb_ld_data;
  logic [DATA_W/8-1:0] wb_ld_be;

  assign in_spec      = (state == ST_SPEC);
  assign conflict_evt = in_spec && snp_valid && (wb_snp_hit || (snp_inv && rs_snp_hit));
  assign overflow_evt = in_spec && ((st_valid && !wb_st_hit && wb_full) || rs_ovf);
  assign abort_evt    = conflict_evt || overflow_evt || (in_spec && ctl_abort);
  assign store_en     = in_spec && st_valid && !abort_evt;

  swb_store_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .LINE_SHIFT(LINE_SHIFT)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(clear), .st_en(store_en),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .gnt_valid(own_gnt_valid), .gnt_line(own_gnt_line),
    .ld_addr(ld_addr), .snp_line(snp_line), .rd_idx(drain_ptr),
    .st_hit(wb_st_hit), .full(wb_full), .occ(wb_occ),
    .ld_match(wb_ld_match), .ld_data(wb_ld_data), .ld_be(wb_ld_be),
    .snp_hit(wb_snp_hit), .all_granted(wb_all_gnt),
    .rd_addr(drain_addr), .rd_data(drain_data), .rd_be(drain_be)
  );

  swb_read_set #(.LINE_W(LINE_W), .RSET_DEPTH(RSET_DEPTH)) u_rset (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .rec_en(in_spec && ld_valid), .rec_line(ld_addr[ADDR_W-1:LINE_SHIFT]),
    .snp_line(snp_line), .rec_ovf(rs_ovf), .snp_hit(rs_snp_hit), .occ(rs_occ)
  );

  swb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .begin_req(ctl_begin), .commit_req(ctl_commit),
    .core_abort(ctl_abort), .conflict(conflict_evt), .overflow(overflow_evt),
    .store_now(st_valid), .all_granted(wb_all_gnt), .occ(wb_occ),
    .state(state), .clear(clear), .commit_take(commit_take), .drain_ptr(drain_ptr),
    .abort_pulse(abort_pulse), .abort_cause(abort_cause), .commit_done(commit_done)
  );

  assign spec_active   = in_spec;
  assign snp_stall     = (state == ST_DRAIN);
  assign drain_valid   = (state == ST_DRAIN);
  assign commit_ready  = wb_all_gnt;
  assign own_req_valid = store_en && !wb_st_hit && !wb_full;
  assign own_req_line  = st_addr[ADDR_W-1:LINE_SHIFT];
  assign ld_hit        = in_spec && ld_valid && wb_ld_match;
  assign ld_fwd_data   = ld_hit ? wb_ld_data : '0;
  assign ld_fwd_be     = ld_hit ? wb_ld_be : '0;
endmodule

// File: rtl/swb_chk.sv
`timescale 1ns/1ps
module swb_chk #(
  parameter int ENTRIES    = 4,
  parameter int RSET_DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic abort_pulse,
  input logic [1:0] abort_cause,
  input logic spec_active,
  input logic drain_valid,
  input logic snp_stall,
  input logic commit_ready,
  input logic commit_done,
  input logic own_req_valid,
  input logic st_valid,
  input logic [$clog2(ENTRIES+1)-1:0] wb_occ,
  input logic [$clog2(RSET_DEPTH+1)-1:0] rs_occ
);
  // R9
  abort_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
  // R9
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> abort_cause != 2'd0);
  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (wb_occ == '0 && rs_occ == '0 && !spec_active));
  // R6
  no_drain_in_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_active |-> !drain_valid);
  // R11
  drain_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> snp_stall);
  // R11
  done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |-> !snp_stall && !spec_active);
  // R10
  drain_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snp_stall) |-> $past(commit_ready));
  // R3
  own_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_req_valid |-> st_valid && spec_active);
  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_occ <= ($clog2(ENTRIES+1))'(ENTRIES));
endmodule

bind swb_top swb_chk #(.ENTRIES(ENTRIES), .RSET_DEPTH(RSET_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort_pulse(abort_pulse), .abort_cause(abort_cause),
  .spec_active(spec_active), .drain_valid(drain_valid), .snp_stall(snp_stall),
  .commit_ready(commit_ready), .commit_done(commit_done),
  .own_req_valid(own_req_valid), .st_valid(st_valid),
  .wb_occ(wb_occ), .rs_occ(rs_occ)
);

// File: tb/swb_top_tb.sv
`timescale 1ns/1ps
module swb_top_tb;
  localparam int AW = 16, DW = 32, BW = 4, LW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_begin = 0, ctl_commit = 0, ctl_abort = 0;
  logic st_valid = 0; logic [AW-1:0] st_addr = '0; logic [DW-1:0] st_data = '0; logic [BW-1:0] st_be = '0;
  logic ld_valid = 0; logic [AW-1:0] ld_addr = '0;
  logic ld_hit; logic [DW-1:0] ld_fwd_data; logic [BW-1:0] ld_fwd_be;
  logic snp_valid = 0, snp_inv = 0; logic [LW-1:0] snp_line = '0;
  logic snp_stall, own_req_valid; logic [LW-1:0] own_req_line;
  logic own_gnt_valid = 0; logic [LW-1:0] own_gnt_line = '0;
  logic commit_ready, drain_valid, commit_done, abort_pulse, spec_active;
  logic [AW-1:0] drain_addr; logic [DW-1:0] drain_data; logic [BW-1:0] drain_be;
  logic [1:0] abort_cause;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  swb_top u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_begin(ctl_begin), .ctl_commit(ctl_commit), .ctl_abort(ctl_abort),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_fwd_data(ld_fwd_data), .ld_fwd_be(ld_fwd_be),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_inv(snp_inv), .snp_stall(snp_stall),
    .own_req_valid(own_req_valid), .own_req_line(own_req_line),
    .own_gnt_valid(own_gnt_valid), .own_gnt_line(own_gnt_line), .commit_ready(commit_ready),
    .drain_valid(drain_valid), .drain_addr(drain_addr), .drain_data(drain_data), .drain_be(drain_be),
    .commit_done(commit_done), .abort_pulse(abort_pulse), .abort_cause(abort_cause), .spec_active(spec_active)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [BW-1:0] be);
    logic [DW-1:0] r = o;
    for (int b = 0; b < BW; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] msk(input logic [DW-1:0] d, input logic [BW-1:0] be);
    logic [DW-1:0] r = '0;
    for (int b = 0; b < BW; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  // store for one cycle, checking the ownership request in that cycle
  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be,
                       input logic exp_req, input string req);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    #1;
    chk(req, own_req_valid, exp_req);
    if (exp_req) chk(req, own_req_line, a >> 2);
    step();
    st_valid = 0;
  endtask

  task automatic pulse_begin();
    ctl_begin = 1; step(); ctl_begin = 0;
  endtask

  task automatic grant(input logic [LW-1:0] l);
    own_gnt_valid = 1; own_gnt_line = l; step(); own_gnt_valid = 0;
  endtask

  task automatic expect_abort(input logic [1:0] cause, input string req);
    chk(req, abort_pulse, 1); chk(req, abort_cause, cause); chk(req, spec_active, 0);
    step();
    chk(req, abort_pulse, 0);
  endtask

  logic [AW-1:0] m_addr [4];
  logic [DW-1:0] m_data [4];
  logic [BW-1:0] m_be [4];
  int m_n;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {spec_active, abort_pulse, commit_done, drain_valid, snp_stall, own_req_valid}, 0);

    // R2 store outside a region ignored
    store(16'h0010, 32'hDEADBEEF, 4'hF, 0, "R2");
    pulse_begin();
    chk("R2", spec_active, 1);
    ld_valid = 1; ld_addr = 16'h0010; #1;
    chk("R2", ld_hit, 0);
    step(); ld_valid = 0;

    // R3 allocation and request; R4 merge; R5 forwarding; R6 no drain
    store(16'h0020, 32'h11223344, 4'h3, 1, "R3");
    ld_valid = 1; ld_addr = 16'h0020; #1;
    chk("R5", ld_hit, 1); chk("R5", ld_fwd_be, 4'h3); chk("R5", ld_fwd_data, 32'h00003344);
    step(); ld_valid = 0;
    store(16'h0020, 32'hAABBCCDD, 4'hC, 0, "R4");
    ld_valid = 1; ld_addr = 16'h0020; #1;
    chk("R4", ld_fwd_be, 4'hF); chk("R4", ld_fwd_data, 32'hAABB3344);
    ld_addr = 16'h0021; #1;
    chk("R5", ld_hit, 0);
    step(); ld_valid = 0;
    chk("R6", drain_valid, 0);

    // R9 core abort, buffer cleared
    ctl_abort = 1; step(); ctl_abort = 0;
    expect_abort(2'd3, "R9");
    pulse_begin();
    ld_valid = 1; ld_addr = 16'h0020; #1;
    chk("R9", ld_hit, 0);
    step(); ld_valid = 0;
    ctl_abort = 1; step(); ctl_abort = 0; step();

    // R7 store overflow
    pulse_begin();
    for (int i = 0; i < 4; i++) store(16'h0010 + 16'(4*i), 32'(i), 4'hF, 1, "R3");
    store(16'h0010, 32'h55, 4'h1, 0, "R4");
    store(16'h0040, 32'h66, 4'hF, 0, "R7");
    expect_abort(2'd2, "R7");

    // R7 read-set overflow
    pulse_begin();
    for (int i = 0; i <= 4; i++) begin
      ld_valid = 1; ld_addr = 16'h0100 + 16'(4*i); step();
    end
    ld_valid = 0;
    expect_abort(2'd2, "R7");

    // R8 read line: read snoop fine, invalidate conflicts
    pulse_begin();
    ld_valid = 1; ld_addr = 16'h0040; step(); ld_valid = 0;
    snp_valid = 1; snp_inv = 0; snp_line = 14'h10; step(); snp_valid = 0;
    chk("R8", abort_pulse, 0); chk("R8", spec_active, 1);
    snp_valid = 1; snp_inv = 1; snp_line = 14'h11; step(); snp_valid = 0;
    chk("R8", abort_pulse, 0);
    snp_valid = 1; snp_inv = 1; snp_line = 14'h10; step(); snp_valid = 0;
    expect_abort(2'd1, "R8");

    // R8 written line: read snoop conflicts
    pulse_begin();
    store(16'h0080, 32'h1, 4'hF, 1, "R3");
    snp_valid = 1; snp_inv = 0; snp_line = 14'h20; step(); snp_valid = 0;
    expect_abort(2'd1, "R8");

    // R12 conflict beats overflow, overflow beats core abort
    pulse_begin();
    for (int i = 0; i < 4; i++) store(16'h0200 + 16'(4*i), 32'(i), 4'hF, 1, "R3");
    st_valid = 1; st_addr = 16'h0300; st_be = 4'hF;
    snp_valid = 1; snp_inv = 1; snp_line = 14'h80; step(); st_valid = 0; snp_valid = 0;
    expect_abort(2'd1, "R12");
    pulse_begin();
    for (int i = 0; i < 4; i++) store(16'h0200 + 16'(4*i), 32'(i), 4'hF, 1, "R3");
    st_valid = 1; st_addr = 16'h0300; ctl_abort = 1; step(); st_valid = 0; ctl_abort = 0;
    expect_abort(2'd2, "R12");

    // R10 commit gating, R11 drain order
    pulse_begin();
    store(16'h0100, 32'h11223344, 4'hF, 1, "R3");
    store(16'h0104, 32'h00005566, 4'h3, 1, "R3");
    store(16'h0100, 32'hAA000000, 4'h8, 0, "R4");
    chk("R10", commit_ready, 0);
    ctl_commit = 1; step(); ctl_commit = 0;
    chk("R10", spec_active, 1); chk("R10", drain_valid, 0);
    grant(14'h40);
    chk("R10", commit_ready, 0);
    grant(14'h41);
    chk("R10", commit_ready, 1);
    ctl_commit = 1; st_valid = 1; st_addr = 16'h0100; st_be = 4'h0; step(); st_valid = 0; ctl_commit = 0;
    chk("R10", drain_valid, 0);
    ctl_commit = 1; step(); ctl_commit = 0;
    chk("R11", drain_valid, 1); chk("R11", snp_stall, 1);
    chk("R11", drain_addr, 16'h0100); chk("R11", drain_data, 32'hAA223344); chk("R11", drain_be, 4'hF);
    step();
    chk("R11", drain_valid, 1); chk("R11", drain_addr, 16'h0104);
    chk("R11", drain_data, 32'h00005566); chk("R11", drain_be, 4'h3);
    step();
    chk("R11", commit_done, 1); chk("R11", drain_valid, 0); chk("R11", snp_stall, 0);
    step();
    chk("R11", commit_done, 0);

    // R11 empty commit
    pulse_begin();
    ctl_commit = 1; step(); ctl_commit = 0;
    chk("R11", commit_done, 1); chk("R11", spec_active, 0);
    step();

    // random rounds: R3 R4 R5 R11
    for (int r = 0; r < 20; r++) begin
      pulse_begin();
      m_n = 0;
      for (int k = 0; k < 8; k++) begin
        logic [AW-1:0] a; logic [DW-1:0] d; logic [BW-1:0] be; int hit;
        a  = 16'h0300 + 16'(($urandom % 2) * 4) + 16'($urandom % 2);
        d  = $urandom; be = 4'($urandom);
        hit = -1;
        for (int j = 0; j < m_n; j++) if (m_addr[j] == a) hit = j;
        store(a, d, be, hit < 0, hit < 0 ? "R3" : "R4");
        if (hit < 0) begin
          m_addr[m_n] = a; m_data[m_n] = msk(d, be); m_be[m_n] = be; m_n++;
        end else begin
          m_data[hit] = mrg(m_data[hit], d, be); m_be[hit] = m_be[hit] | be;
        end
        ld_valid = 1; ld_addr = 16'h0300 + 16'(($urandom % 2) * 4) + 16'($urandom % 2); #1;
        hit = -1;
        for (int j = 0; j < m_n; j++) if (m_addr[j] == ld_addr) hit = j;
        chk("R5", ld_hit, hit >= 0);
        if (hit >= 0) begin
          chk("R5", ld_fwd_be, m_be[hit]); chk("R5", ld_fwd_data, msk(m_data[hit], m_be[hit]));
        end
        step(); ld_valid = 0;
      end
      grant(14'hC0); grant(14'hC1);
      chk("R10", commit_ready, 1);
      ctl_commit = 1; step(); ctl_commit = 0;
      for (int j = 0; j < m_n; j++) begin
        chk("R11", drain_valid, 1);
        chk("R11", drain_addr, m_addr[j]); chk("R11", drain_data, msk(m_data[j], m_be[j]));
        chk("R11", drain_be, m_be[j]);
        step();
      end
      chk("R11", commit_done, 1);
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule